// File: doc/BRIEF.md
# Three-Wire SPI Gain and Channel Controller

This block is the digital front end of a programmable-gain amplifier that is configured over a three-wire serial port: a clock, an active-low select and one data line shared by both directions. It samples the serial pins with its own system clock. It assembles 16-bit command words and checks at select release that the frame carried a valid number of clocks. If the frame is valid, it updates a small configuration register. That register holds a 4-bit gain code, a 4-bit input channel code and a shutdown flag, and it drives the analog gain ladder and input multiplexer directly.

A read command changes the data line's direction for the next frame. During that frame the block drives the register contents onto the line, and it then returns to receiving. Frames with a clock count that is not a whole multiple of 16 are dropped without effect. A host can therefore re-align the interface with a short or padded dummy frame. Gain codes 0 to 7 select gains of 1 to 128 in powers of two, or 1, 2, 5, 10, 20, 50, 100 and 200 in the decade-stepped variant. Channel codes 0 and 1 select the external inputs, and codes 12 to 15 select the four calibration sources.

Top module: `pga_spi3_ctrl`

## Requirements
- R1: After reset, gain_code is 0, chan_code is 0, shutdown is 0 and dio_oe is 0, and the data line is in receive direction.
- R2: A word whose bits 15:8 equal 0x2A and whose bit 7 is 0 loads gain_code from bits 7:4 and chan_code from bits 3:0. The new values appear only after chip select rises, never while the frame is still open.
- R3: A frame with 0 clocks, or with a rising-edge count that is not a multiple of 16 (for example 8, 15 or 17), changes neither the register nor the data line direction.
- R4: A frame of 32 (or any larger multiple of 16) clocks decodes only the last 16 bits shifted in, MSB first.
- R5: Word 0xE1F1 sets shutdown and word 0xE100 clears it. Word 0x0000 changes nothing.
- R6: Any other word leaves the register unchanged. This includes a 0x2A-headed word with bit 7 set.
- R7: After a valid read word 0x6A00, the next frame drives dio_oe high while chip select is low. It shifts out {0x2A, gain_code, chan_code} MSB first. The first bit is valid before the first rising clock edge, and later bits change only after falling clock edges.
- R8: A response frame of valid length returns the line to receive direction, and its incoming bits are not decoded. A response frame of invalid length keeps the line in transmit direction for the following frame.
- R9: dio_oe is 0 whenever chip select is high.
- R10: Clock idle-low and clock idle-high operation give identical writes and read-back. Data is sampled on rising edges in both cases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low chip select |
| dio_in | input | 1 | Receive path of the shared data pin |
| dio_out | output | 1 | Transmit path of the shared data pin |
| dio_oe | output | 1 | Output enable for the data pin driver |
| gain_code | output | 4 | Selected gain code |
| chan_code | output | 4 | Selected input channel code |
| shutdown | output | 1 | Software shutdown request |

## Verification
The bench builds the block with its default two-stage pin synchronizers. It drives the serial clock with a half period of six system clocks, which keeps every pin edge well outside the three-cycle detection latency. At this setting the bench can sample each output bit one half period after the falling edge in both clock polarities. It can also show that register outputs stay unchanged between the last clock of a frame and the chip-select release. The bench covers frames of 0, 8, 15, 16, 17 and 32 clocks, read-back in both polarities, and a truncated response frame.

// File: rtl/pga_spi3_pkg.sv
package pga_spi3_pkg;
  localparam int unsigned CMD_W  = 16;
  localparam int unsigned GAIN_W = 4;
  localparam int unsigned CHAN_W = 4;

  localparam logic [CMD_W-1:0] CMD_READ   = 16'h6A00;
  localparam logic [CMD_W-1:0] CMD_NOP    = 16'h0000;
  localparam logic [CMD_W-1:0] CMD_SD_ON  = 16'hE1F1;
  localparam logic [CMD_W-1:0] CMD_SD_OFF = 16'hE100;
  localparam logic [7:0]       WR_HDR     = 8'h2A;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [CHAN_W-1:0] chan;
    logic              sd;
  } cfg_t;
endpackage

// File: rtl/pga_spi3_sync.sv
module pga_spi3_sync #(
  parameter int              STAGES  = 2,
  parameter int              NSIG    = 3,
  parameter logic [NSIG-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSIG-1:0] async_in,
  output logic [NSIG-1:0] lvl,
  output logic [NSIG-1:0] rise,
  output logic [NSIG-1:0] fall
);
  logic [NSIG-1:0] prev_q;

  for (genvar g = 0; g < NSIG; g++) begin : g_sig
    logic [STAGES-1:0] sh_q;
    logic [STAGES-1:0] sh_d;

    always_comb sh_d = {sh_q[STAGES-2:0], async_in[g]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {STAGES{RST_VAL[g]}};
      else        sh_q <= sh_d;
    end

    assign lvl[g] = sh_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pga_spi3_rx.sv
module pga_spi3_rx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              bit_stb,
  input  logic              bit_in,
  output logic [WORD_W-1:0] word,
  output logic              len_ok,
  output logic              any_bit
);
  localparam int CNT_W = $clog2(WORD_W);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              full_q, full_d;
  logic [WORD_W-1:0] sh_q, sh_d;
  logic              en;

  always_comb begin
    en     = frame_start | bit_stb;
    cnt_d  = cnt_q;
    full_d = full_q;
    sh_d   = sh_q;
    if (frame_start) begin
      cnt_d  = '0;
      full_d = 1'b0;
    end else if (bit_stb) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == CNT_W'(WORD_W - 1)) full_d = 1'b1;
      sh_d = {sh_q[WORD_W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      full_q <= 1'b0;
      sh_q   <= '0;
    end else if (en) begin
      cnt_q  <= cnt_d;
      full_q <= full_d;
      sh_q   <= sh_d;
    end
  end

  assign word    = sh_q;
  assign len_ok  = full_q & (cnt_q == '0);
  assign any_bit = full_q | (cnt_q != '0);

  // R3: every frame starts with a cleared clock count
  a_r3_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> (cnt_q == '0) && !full_q);

  // R4: each sampled bit enters at the LSB, older bits move up
  a_r4_shift_order: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && !frame_start) |=>
      (sh_q[0] == $past(bit_in)) && (sh_q[WORD_W-1:1] == $past(sh_q[WORD_W-2:0])));
endmodule

// File: rtl/pga_spi3_cmd.sv
module pga_spi3_cmd
  import pga_spi3_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frame_end,
  input  logic             len_ok,
  input  logic [CMD_W-1:0] word,
  output cfg_t             cfg,
  output logic             resp_mode
);
  cfg_t cfg_q, cfg_d;
  logic resp_q, resp_d;
  logic commit;

  always_comb begin
    commit = frame_end & len_ok;
    cfg_d  = cfg_q;
    resp_d = resp_q;
    if (commit) begin
      if (resp_q) begin
        resp_d = 1'b0;
      end else if (word == CMD_READ) begin
        resp_d = 1'b1;
      end else if (word == CMD_SD_ON) begin
        cfg_d.sd = 1'b1;
      end else if (word == CMD_SD_OFF) begin
        cfg_d.sd = 1'b0;
      end else if (word[15:8] == WR_HDR && !word[7]) begin
        cfg_d.gain = word[7:4];
        cfg_d.chan = word[3:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      resp_q <= 1'b0;
    end else if (commit) begin
      cfg_q  <= cfg_d;
      resp_q <= resp_d;
    end
  end

  assign cfg       = cfg_q;
  assign resp_mode = resp_q;

  // R2: configuration moves only on a chip-select release
  a_r2_commit_at_release: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_end |=> $stable(cfg_q) && $stable(resp_q));

  // R3: a bad-length frame touches nothing
  a_r3_bad_len_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !len_ok) |=> $stable(cfg_q) && $stable(resp_q));

  // R6: a gain code above 7 never reaches the register
  a_r6_gain_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.gain[GAIN_W-1] == 1'b0);

  // R8: a valid response frame returns the line to receive
  a_r8_resp_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_q && frame_end && len_ok) |=> !resp_q);
endmodule

// File: rtl/pga_spi3_tx.sv
module pga_spi3_tx #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              shift_stb,
  input  logic              cs_active,
  input  logic              resp_mode,
  input  logic [WORD_W-1:0] load_word,
  output logic              dio_out,
  output logic              dio_oe
);
  logic [WORD_W-1:0] tx_q, tx_d;
  logic              en;

  always_comb begin
    en   = frame_start | shift_stb;
    tx_d = tx_q;
    if (frame_start)    tx_d = load_word;
    else if (shift_stb) tx_d = {tx_q[WORD_W-2:0], 1'b0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  tx_q <= '0;
    else if (en) tx_q <= tx_d;
  end

  assign dio_out = tx_q[WORD_W-1];
  assign dio_oe  = resp_mode & cs_active;

  // R7: outgoing bit changes only at frame start or after a falling clock edge
  a_r7_out_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame_start && !shift_stb) |=> $stable(dio_out));
endmodule

// File: rtl/pga_spi3_ctrl.sv
module pga_spi3_ctrl
  import pga_spi3_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              dio_in,
  output logic              dio_out,
  output logic              dio_oe,
  output logic [GAIN_W-1:0] gain_code,
  output logic [CHAN_W-1:0] chan_code,
  output logic              shutdown
);
  localparam int PIN_SCLK = 0;
  localparam int PIN_DIO  = 1;
  localparam int PIN_CS   = 2;

  logic [1:0] rst_pipe_q;
  logic       rst_ni;
  logic [2:0] pin_lvl, pin_rise, pin_fall;
  logic       cs_active, frame_start, frame_end, bit_stb, shift_stb;
  logic [CMD_W-1:0] rx_word, tx_word;
  logic       len_ok, any_bit, resp_mode;
  cfg_t       cfg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_ni = rst_pipe_q[1];

  pga_spi3_sync #(
    .STAGES (SYNC_STAGES),
    .NSIG   (3),
    .RST_VAL(3'b100)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_ni),
    .async_in({spi_cs_n, dio_in, spi_sclk}),
    .lvl     (pin_lvl),
    .rise    (pin_rise),
    .fall    (pin_fall)
  );

  assign cs_active   = ~pin_lvl[PIN_CS];
  assign frame_start = pin_fall[PIN_CS];
  assign frame_end   = pin_rise[PIN_CS];
  assign bit_stb     = pin_rise[PIN_SCLK] & cs_active;
  assign shift_stb   = pin_fall[PIN_SCLK] & cs_active & any_bit;

  pga_spi3_rx #(.WORD_W(CMD_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_ni),
    .frame_start(frame_start),
    .bit_stb    (bit_stb),
    .bit_in     (pin_lvl[PIN_DIO]),
    .word       (rx_word),
    .len_ok     (len_ok),
    .any_bit    (any_bit)
  );

  pga_spi3_cmd u_cmd (
    .clk      (clk),
    .rst_n    (rst_ni),
    .frame_end(frame_end),
    .len_ok   (len_ok),
    .word     (rx_word),
    .cfg      (cfg),
    .resp_mode(resp_mode)
  );

  assign tx_word = {WR_HDR, cfg.gain, cfg.chan};

  pga_spi3_tx #(.WORD_W(CMD_W)) u_tx (
    .clk        (clk),
    .rst_n      (rst_ni),
    .frame_start(frame_start),
    .shift_stb  (shift_stb),
    .cs_active  (cs_active),
    .resp_mode  (resp_mode),
    .load_word  (tx_word),
    .dio_out    (dio_out),
    .dio_oe     (dio_oe)
  );

  assign gain_code = cfg.gain;
  assign chan_code = cfg.chan;
  assign shutdown  = cfg.sd;

  // R9: no drive on the data line while select is high
  a_r9_hiz_when_idle: assert property (@(posedge clk) disable iff (!rst_ni)
    pin_lvl[PIN_CS] |-> !dio_oe);
endmodule

// File: tb/pga_spi3_ctrl_test.sv
module pga_spi3_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int H = 6;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi;
  logic dout, oe, sd;
  logic [3:0] gain, chan;
  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pga_spi3_ctrl uut (
    .clk      (clk),
    .rst_n    (rst_n),
    .spi_sclk (sclk),
    .spi_cs_n (cs_n),
    .dio_in   (mosi),
    .dio_out  (dout),
    .dio_oe   (oe),
    .gain_code(gain),
    .chan_code(chan),
    .shutdown (sd)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic frame_open(input bit cpol);
    sclk = cpol;
    repeat (H) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame_bits(input logic [63:0] v, input int n,
                            output logic [63:0] got, output int oe_n);
    got = '0;
    oe_n = 0;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0;
      mosi = v[n-1-i];
      repeat (H) @(negedge clk);
      got = {got[62:0], dout};
      if (oe) oe_n++;
      sclk = 1'b1;
      repeat (H) @(negedge clk);
    end
  endtask

  task automatic frame_close(input bit cpol);
    sclk = cpol;
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic xfer(input logic [63:0] v, input int n, input bit cpol,
                      output logic [63:0] got, output int oe_n);
    frame_open(cpol);
    frame_bits(v, n, got, oe_n);
    frame_close(cpol);
  endtask

  task automatic t_reset;
    chk("R1", "gain", gain, 0);
    chk("R1", "chan", chan, 0);
    chk("R1", "shutdown", sd, 0);
    chk("R1", "oe", oe, 0);
  endtask

  task automatic t_write;
    logic [63:0] g; int o;
    frame_open(1'b0);
    frame_bits(64'h2A53, 16, g, o);
    chk("R2", "gain before release", gain, 0);
    frame_close(1'b0);
    chk("R2", "gain", gain, 5);
    chk("R2", "chan", chan, 3);
  endtask

  task automatic t_length;
    logic [63:0] g; int o;
    xfer(64'h2A21 >> 1, 15, 1'b0, g, o);
    chk("R3", "gain after 15 clocks", gain, 5);
    xfer({47'd0, 17'h02A21}, 17, 1'b0, g, o);
    chk("R3", "chan after 17 clocks", chan, 3);
    xfer(64'h0, 0, 1'b0, g, o);
    chk("R3", "gain after 0 clocks", gain, 5);
    xfer(64'h6A, 8, 1'b0, g, o);
    xfer(64'h6A00 >> 1, 15, 1'b0, g, o);
    xfer(64'h0, 16, 1'b0, g, o);
    chk("R3", "no turnaround after short read", o, 0);
  endtask

  task automatic t_long;
    logic [63:0] g; int o;
    xfer(64'h2A77_2A12, 32, 1'b0, g, o);
    chk("R4", "gain from last word", gain, 1);
    chk("R4", "chan from last word", chan, 2);
  endtask

  task automatic t_shutdown;
    logic [63:0] g; int o;
    xfer(64'hE1F1, 16, 1'b0, g, o);
    chk("R5", "shutdown set", sd, 1);
    xfer(64'h0000, 16, 1'b0, g, o);
    chk("R5", "nop keeps shutdown", sd, 1);
    chk("R5", "nop keeps gain", gain, 1);
    xfer(64'hE100, 16, 1'b0, g, o);
    chk("R5", "shutdown cleared", sd, 0);
  endtask

  task automatic t_reject;
    logic [63:0] g; int o;
    xfer(64'h2A93, 16, 1'b0, g, o);
    chk("R6", "gain msb rejected", gain, 1);
    chk("R6", "chan kept", chan, 2);
    xfer(64'h2B45, 16, 1'b0, g, o);
    chk("R6", "bad header", gain, 1);
    xfer(64'hE1F0, 16, 1'b0, g, o);
    chk("R6", "near shutdown word", sd, 0);
  endtask

  task automatic t_read;
    logic [63:0] g; int o;
    xfer(64'h2A6C, 16, 1'b0, g, o);
    xfer(64'h6A00, 16, 1'b0, g, o);
    chk("R9", "oe idle after read", oe, 0);
    xfer(64'hE1F1, 16, 1'b0, g, o);
    chk("R7", "readback word", int'(g[15:0]), 16'h2A6C);
    chk("R7", "oe bits", o, 16);
    chk("R8", "response not decoded", sd, 0);
    xfer(64'h2A10, 16, 1'b0, g, o);
    chk("R8", "back to receive", o, 0);
    chk("R8", "write after response", gain, 1);
  endtask

  task automatic t_read_short;
    logic [63:0] g; int o;
    xfer(64'h6A00, 16, 1'b0, g, o);
    xfer(64'h0, 8, 1'b0, g, o);
    chk("R8", "short response header", int'(g[7:0]), 8'h2A);
    xfer(64'h0, 16, 1'b0, g, o);
    chk("R8", "still transmitting", o, 16);
    chk("R8", "repeat word", int'(g[15:0]), 16'h2A10);
  endtask

  task automatic t_mode_high;
    logic [63:0] g; int o;
    xfer(64'h2A47, 16, 1'b1, g, o);
    chk("R10", "gain idle-high", gain, 4);
    chk("R10", "chan idle-high", chan, 7);
    xfer(64'h6A00, 16, 1'b1, g, o);
    xfer(64'h0, 16, 1'b1, g, o);
    chk("R10", "readback idle-high", int'(g[15:0]), 16'h2A47);
    chk("R10", "oe idle-high", o, 16);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    t_reset;
    t_write;
    t_length;
    t_long;
    t_shutdown;
    t_reject;
    t_read;
    t_read_short;
    t_mode_high;
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule